// File: doc/BRIEF.md
# Speculative Store Dirty-Bit Gate

This block sits between the memory pipeline of an out-of-order core and the line-state array of a second-level cache. Each store or load request arrives with the state its line has in the cache. The block then decides whether the line state may change now, whether a refill from memory must start and in which state it lands, and whether the request has to be replayed. When the delayed-dirty mode applies to the privilege level of the request, a store that is still speculative never makes a line dirty. Bus work still starts early: a miss refills the line as clean exclusive, and a hit on a shared line is upgraded to clean exclusive. The clean-to-dirty step is taken only when the store is the oldest entry in the reorder list. That step then occupies a fixed busy window of `DIRTY_LAT` cycles, after which a dirty-set command leaves the block carrying the tag of the store.

Two inputs select the mode. For kernel and supervisor requests, the mode comes from a configuration bit that is captured while reset is held and cannot change afterwards. For user requests, the mode comes from a status bit that software may write at any time. Whatever the mode, a cached non-coherent load is held back until it is the oldest instruction, so that it cannot bring a line into the cache without coherency checks. No other refill is ever blocked. A squash from an older instruction cancels a dirty-set that is still waiting to complete.

Top module: `spec_dirty_gate`

## Requirements
- R1: The kernel (`reqPriv`=00) and supervisor (01) modes use the value of `bootDelayCfg` captured while `rstN` is low, and later changes of that input have no effect. The user mode (10, and 11 is treated the same) uses `userDelayEn` as it stands at that moment.
- R2: With the mode off, a store whose line is invalid (00) gives `refillValid`=1 with `refillState`=11 (dirty exclusive). A store on a shared (01) or clean exclusive (10) line gives `updValid`=1 with `updState`=11. None of these sets `stall`.
- R3: With the mode on, a store whose line is invalid gives `refillValid` with `refillState`=10 and `stall`=1. A store on a shared line gives `updValid` with `updState`=10 and `stall`=1. A store on a clean exclusive line that is not oldest gives only `stall`=1. These hold for a store of any age.
- R4: With the mode on, an oldest store on a clean exclusive line, arriving while no dirty-set is pending and with no squash, gives `stall`=0 and raises `dirtyBusy`. Exactly `DIRTY_LAT` clock edges after it is accepted, `dirtySetValid` pulses for one cycle with `dirtySetTag` equal to the tag of the store. Other requests keep being served in the meantime.
- R5: A store on a dirty exclusive (11) line gives no update, no refill and no stall, in either mode.
- R6: A cached non-coherent load (`reqIsNcLoad`=1, `reqIsStore`=0) that is not oldest gives `stall`=1 and no refill. Once it is oldest, a miss refills as shared (01) with no stall.
- R7: An ordinary load never stalls. A miss refills as shared (01) whatever the age of the load, and a hit causes no action.
- R8: `squash` cancels a pending dirty-set. One cycle later `dirtyBusy` is 0, and no `dirtySetValid` follows.
- R9: A store with the mode on that would start a dirty-set while one is already pending gets `stall`=1, and the pending dirty-set keeps its timing and its tag.
- R10: During reset and after it, every output is 0 until the first request.
- R11: All request outputs (`updValid`/`updState`, `refillValid`/`refillState`, `stall`) are registered, so they appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; captures the boot mode bit |
| bootDelayCfg | input | 1 | Boot-time delayed-dirty enable for kernel and supervisor modes |
| userDelayEn | input | 1 | Software status bit enabling delayed-dirty mode for user requests |
| reqValid | input | 1 | A request is present this cycle |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqIsNcLoad | input | 1 | Load is cached non-coherent (ignored for stores) |
| reqPriv | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| reqOldest | input | 1 | Request is the oldest entry in the reorder list |
| reqTag | input | TAG_W | Reorder-list tag of the request |
| lineState | input | 2 | Looked-up line state: 00 invalid, 01 shared, 10 clean excl, 11 dirty excl |
| squash | input | 1 | Older-instruction flush; cancels a pending dirty-set |
| updValid | output | 1 | Line-state update command valid |
| updState | output | 2 | New state for the update command |
| refillValid | output | 1 | Refill request valid |
| refillState | output | 2 | State the refilled line lands in |
| stall | output | 1 | Request must be replayed |
| dirtySetValid | output | 1 | Delayed dirty-set command (one-cycle pulse) |
| dirtySetTag | output | TAG_W | Tag of the store whose dirty-set completes |
| dirtyBusy | output | 1 | A delayed dirty-set is pending |

## Verification
The bench builds the block with `TAG_W`=4 and `DIRTY_LAT`=10, which is the default latency. With these values it counts the busy window edge by edge and checks that the pulse arrives on the tenth edge and not the ninth. It also puts a squash and a competing store inside that window. It resets twice with opposite boot bits to show that a later change of the boot input is ignored, while the user status bit takes effect at once.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_CLX = 2'b10,
    LS_DTY = 2'b11
  } lineState_e;

  // Strobes from control to datapath, registered there.
  typedef struct packed {
    logic       startDirty;
    logic       updEn;
    lineState_e updState;
    logic       refillEn;
    lineState_e refillState;
    logic       stall;
  } gateCmd_t;
endpackage

// File: rtl/sdg_mode.sv
module sdg_mode (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bootDelayCfg,
  input  logic       userDelayEn,
  input  logic [1:0] reqPriv,
  output logic       delayActive
);
  logic bootLatch;

  // Boot bit is captured only while reset is held; read-only afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) bootLatch <= bootDelayCfg;
  end

  // Upper privilege bit set means user mode.
  always_comb begin
    if (reqPriv[1]) delayActive = userDelayEn;
    else            delayActive = bootLatch;
  end
endmodule

// File: rtl/sdg_ctrl.sv
module sdg_ctrl
  import sdg_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqIsStore,
  input  logic       reqIsNcLoad,
  input  logic       reqOldest,
  input  logic [1:0] lineState,
  input  logic       delayActive,
  input  logic       dirtyBusy,
  input  logic       squash,
  output gateCmd_t   cmd
);
  lineState_e curState;
  assign curState = lineState_e'(lineState);

  always_comb begin
    cmd = '0;
    if (reqValid) begin
      if (reqIsStore) begin
        unique case (curState)
          LS_DTY: ; // already dirty: nothing to do
          LS_INV: begin
            cmd.refillEn    = 1'b1;
            cmd.refillState = delayActive ? LS_CLX : LS_DTY;
            cmd.stall       = delayActive;
          end
          LS_SHR: begin
            cmd.updEn    = 1'b1;
            cmd.updState = delayActive ? LS_CLX : LS_DTY;
            cmd.stall    = delayActive;
          end
          LS_CLX: begin
            if (!delayActive) begin
              cmd.updEn    = 1'b1;
              cmd.updState = LS_DTY;
            end else if (reqOldest && !dirtyBusy && !squash) begin
              cmd.startDirty = 1'b1;
            end else begin
              cmd.stall = 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        if (reqIsNcLoad && !reqOldest) begin
          cmd.stall = 1'b1;
        end else if (curState == LS_INV) begin
          cmd.refillEn    = 1'b1;
          cmd.refillState = LS_SHR;
        end
      end
    end
  end
endmodule

// File: rtl/sdg_datapath.sv
module sdg_datapath
  import sdg_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int DIRTY_LAT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateCmd_t         cmd,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             squash,
  output logic             updValid,
  output logic [1:0]       updState,
  output logic             refillValid,
  output logic [1:0]       refillState,
  output logic             stall,
  output logic             dirtySetValid,
  output logic [TAG_W-1:0] dirtySetTag,
  output logic             dirtyBusy
);
  localparam int CNT_W = $clog2(DIRTY_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DIRTY_LAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid    <= 1'b0;
      updState    <= 2'b00;
      refillValid <= 1'b0;
      refillState <= 2'b00;
      stall       <= 1'b0;
    end else begin
      updValid    <= cmd.updEn;
      updState    <= cmd.updEn ? cmd.updState : 2'b00;
      refillValid <= cmd.refillEn;
      refillState <= cmd.refillEn ? cmd.refillState : 2'b00;
      stall       <= cmd.stall;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt       <= '0;
      dirtySetValid <= 1'b0;
      dirtySetTag   <= '0;
    end else begin
      dirtySetValid <= 1'b0;
      if (squash) begin
        waitCnt <= '0;
      end else if (cmd.startDirty) begin
        waitCnt     <= CNT_LOAD;
        dirtySetTag <= reqTag;
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - CNT_ONE;
        if (waitCnt == CNT_ONE) dirtySetValid <= 1'b1;
      end
    end
  end

  assign dirtyBusy = (waitCnt != '0);
endmodule

// File: rtl/spec_dirty_gate.sv
module spec_dirty_gate
  import sdg_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int DIRTY_LAT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootDelayCfg,
  input  logic             userDelayEn,
  input  logic             reqValid,
  input  logic             reqIsStore,
  input  logic             reqIsNcLoad,
  input  logic [1:0]       reqPriv,
  input  logic             reqOldest,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [1:0]       lineState,
  input  logic             squash,
  output logic             updValid,
  output logic [1:0]       updState,
  output logic             refillValid,
  output logic [1:0]       refillState,
  output logic             stall,
  output logic             dirtySetValid,
  output logic [TAG_W-1:0] dirtySetTag,
  output logic             dirtyBusy
);
  logic     delayActive;
  gateCmd_t gateCmd;

  sdg_mode u_mode (
    .clk(clk), .rstN(rstN), .bootDelayCfg(bootDelayCfg),
    .userDelayEn(userDelayEn), .reqPriv(reqPriv), .delayActive(delayActive)
  );

  sdg_ctrl u_ctrl (
    .reqValid(reqValid), .reqIsStore(reqIsStore), .reqIsNcLoad(reqIsNcLoad),
    .reqOldest(reqOldest), .lineState(lineState), .delayActive(delayActive),
    .dirtyBusy(dirtyBusy), .squash(squash), .cmd(gateCmd)
  );

  sdg_datapath #(.TAG_W(TAG_W), .DIRTY_LAT(DIRTY_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(gateCmd), .reqTag(reqTag), .squash(squash),
    .updValid(updValid), .updState(updState), .refillValid(refillValid),
    .refillState(refillState), .stall(stall), .dirtySetValid(dirtySetValid),
    .dirtySetTag(dirtySetTag), .dirtyBusy(dirtyBusy)
  );
endmodule

// File: rtl/sdg_checker.sv
module sdg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bootDelayCfg,
  input logic       userDelayEn,
  input logic       reqValid,
  input logic       reqIsStore,
  input logic       reqIsNcLoad,
  input logic [1:0] reqPriv,
  input logic       reqOldest,
  input logic [1:0] lineState,
  input logic       squash,
  input logic       updValid,
  input logic [1:0] updState,
  input logic       refillValid,
  input logic [1:0] refillState,
  input logic       stall,
  input logic       dirtySetValid,
  input logic       dirtyBusy
);
  logic bootSeen;
  logic modeOn;

  always_ff @(posedge clk) begin
    if (!rstN) bootSeen <= bootDelayCfg;
  end
  assign modeOn = (reqPriv == 2'b00 || reqPriv == 2'b01) ? bootSeen : userDelayEn;

  AST_MISS_DIRECT_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && !modeOn && lineState == 2'b00)
      |=> (refillValid && refillState == 2'b11 && !stall)); // R2

  AST_SHARED_TO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && modeOn && lineState == 2'b01)
      |=> (updValid && updState == 2'b10 && stall && !refillValid)); // R3

  AST_SET_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dirtySetValid |-> $past(dirtyBusy)); // R4

  AST_DIRTY_NO_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && lineState == 2'b11)
      |=> (!stall && !updValid && !refillValid)); // R5

  AST_NCLOAD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStore && reqIsNcLoad && !reqOldest)
      |=> (stall && !refillValid)); // R6

  AST_LOAD_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStore && !reqIsNcLoad) |=> !stall); // R7

  AST_SQUASH_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> (!dirtySetValid && !dirtyBusy)); // R8

  AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && modeOn && lineState == 2'b10 && dirtyBusy)
      |=> stall); // R9
endmodule

bind spec_dirty_gate sdg_checker u_chk (
  .clk(clk), .rstN(rstN), .bootDelayCfg(bootDelayCfg), .userDelayEn(userDelayEn),
  .reqValid(reqValid), .reqIsStore(reqIsStore), .reqIsNcLoad(reqIsNcLoad),
  .reqPriv(reqPriv), .reqOldest(reqOldest), .lineState(lineState),
  .squash(squash), .updValid(updValid), .updState(updState),
  .refillValid(refillValid), .refillState(refillState), .stall(stall),
  .dirtySetValid(dirtySetValid), .dirtyBusy(dirtyBusy)
);

// File: tb/tb_spec_dirty_gate.sv
`timescale 1ns/1ps
module tb_spec_dirty_gate;
  localparam int TAG_W     = 4;
  localparam int DIRTY_LAT = 10;
  localparam int NV        = 16;

  logic clk = 1'b0;
  logic rstN, bootDelayCfg, userDelayEn;
  logic reqValid, reqIsStore, reqIsNcLoad, reqOldest, squash;
  logic [1:0] reqPriv, lineState;
  logic [TAG_W-1:0] reqTag;
  logic updValid, refillValid, stall, dirtySetValid, dirtyBusy;
  logic [1:0] updState, refillState;
  logic [TAG_W-1:0] dirtySetTag;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spec_dirty_gate #(.TAG_W(TAG_W), .DIRTY_LAT(DIRTY_LAT)) dut (
    .clk(clk), .rstN(rstN), .bootDelayCfg(bootDelayCfg), .userDelayEn(userDelayEn),
    .reqValid(reqValid), .reqIsStore(reqIsStore), .reqIsNcLoad(reqIsNcLoad),
    .reqPriv(reqPriv), .reqOldest(reqOldest), .reqTag(reqTag),
    .lineState(lineState), .squash(squash), .updValid(updValid),
    .updState(updState), .refillValid(refillValid), .refillState(refillState),
    .stall(stall), .dirtySetValid(dirtySetValid), .dirtySetTag(dirtySetTag),
    .dirtyBusy(dirtyBusy)
  );

  // Fields: reqId[18:15] userEn[14] priv[13:12] store[11] nc[10] oldest[9]
  // line[8:7] expUpdV[6] expUpdS[5:4] expRefV[3] expRefS[2:1] expStall[0]
  // Boot bit is 1 for this table (kernel/supervisor delay on).
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b11, 1'b0}, // R2 miss
    {4'd2, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b11, 1'b0, 2'b00, 1'b0}, // R2 shared
    {4'd2, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 2'b11, 1'b0, 2'b00, 1'b0}, // R2 clean
    {4'd3, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b10, 1'b1}, // R3 miss
    {4'd3, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10, 1'b0, 2'b00, 1'b1}, // R3 shared
    {4'd3, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1}, // R3 clean young
    {4'd1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b10, 1'b0, 2'b00, 1'b1}, // R1 kernel on
    {4'd3, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 2'b10, 1'b1}, // R3 oldest miss
    {4'd5, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R5 on
    {4'd5, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R5 off
    {4'd6, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1}, // R6 young
    {4'd6, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0}, // R6 oldest
    {4'd6, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1}, // R6 young hit
    {4'd7, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0}, // R7 miss
    {4'd7, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R7 hit
    {4'd6, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}  // R6 oldest hit
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqIsStore = 0; reqIsNcLoad = 0; reqOldest = 0;
    reqPriv = 2'b00; reqTag = '0; lineState = 2'b00; squash = 0;
  endtask

  task automatic doReset(input logic bootVal);
    @(negedge clk);
    rstN = 0; bootDelayCfg = bootVal; idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    bootDelayCfg = ~bootVal; // must be ignored from now on
  endtask

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic sendReq(input logic [1:0] priv, input logic st, input logic nc,
                         input logic old, input logic [1:0] ls, input logic [TAG_W-1:0] tg);
    reqValid = 1; reqPriv = priv; reqIsStore = st; reqIsNcLoad = nc;
    reqOldest = old; lineState = ls; reqTag = tg;
    @(posedge clk); @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    rstN = 0; bootDelayCfg = 0; userDelayEn = 0; idle();
    doReset(1'b1);
    // R10: quiet after reset
    check("R10 outputs", {updValid, refillValid, stall, dirtySetValid, dirtyBusy}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      string tagStr;
      v = VEC[i];
      tagStr = $sformatf("R%0d vec%0d", v[18:15], i);
      userDelayEn = v[14];
      sendReq(v[13:12], v[11], v[10], v[9], v[8:7], 4'h0);
      check({tagStr, " upd"}, {updValid, updState}, {v[6], v[5:4]});
      check({tagStr, " refill"}, {refillValid, refillState}, {v[3], v[2:1]});
      check({tagStr, " stall"}, stall, v[0]);
    end

    // R11: outputs register one cycle after request, then clear
    @(negedge clk);
    check("R11 cleared", {updValid, refillValid, stall}, 0);

    // R4: delayed dirty-set timing and tag; other ops proceed
    sendReq(2'b00, 1, 0, 1, 2'b10, 4'hA);
    check("R4 accepted", {stall, updValid, dirtyBusy}, 3'b001);
    for (int k = 1; k <= DIRTY_LAT; k++) begin
      if (k == 2) begin
        reqValid = 1; reqIsStore = 0; reqIsNcLoad = 0; reqOldest = 0; lineState = 2'b00;
      end else if (k == 4) begin
        // R9: competing oldest clean store while busy
        reqValid = 1; reqIsStore = 1; reqOldest = 1; lineState = 2'b10; reqTag = 4'h5;
      end else begin
        reqValid = 0;
      end
      @(negedge clk);
      if (k == 2) check("R4 load proceeds", {refillValid, refillState, stall}, 4'b1010);
      if (k == 4) check("R9 stall while busy", stall, 1);
      if (k < DIRTY_LAT) check("R4 no early set", dirtySetValid, 0);
      else begin
        check("R4 set on time", dirtySetValid, 1);
        check("R4/R9 tag", dirtySetTag, 4'hA);
      end
    end
    reqValid = 0;
    @(negedge clk);
    check("R4 pulse ends", {dirtySetValid, dirtyBusy}, 0);

    // R8: squash cancels pending dirty-set
    sendReq(2'b01, 1, 0, 1, 2'b10, 4'h3);
    check("R8 busy", dirtyBusy, 1);
    @(negedge clk);
    squash = 1;
    @(negedge clk);
    squash = 0;
    check("R8 busy cleared", dirtyBusy, 0);
    begin
      int seen = 0;
      for (int k = 0; k < DIRTY_LAT + 2; k++) begin
        @(negedge clk);
        if (dirtySetValid) seen++;
      end
      check("R8 no set", seen, 0);
    end

    // R1: user bit toggles immediately; boot bit latched at reset
    userDelayEn = 1;
    sendReq(2'b10, 1, 0, 0, 2'b01, 0);
    check("R1 user on", updState, 2'b10);
    userDelayEn = 0;
    sendReq(2'b10, 1, 0, 0, 2'b01, 0);
    check("R1 user off", updState, 2'b11);
    doReset(1'b0); // bootDelayCfg now driven 1, must be ignored
    check("R10 after second reset", {updValid, refillValid, stall, dirtyBusy}, 0);
    sendReq(2'b00, 1, 0, 0, 2'b01, 0);
    check("R1 kernel off", {updValid, updState, stall}, 4'b1110);
    sendReq(2'b01, 1, 0, 1, 2'b10, 0);
    check("R1 supervisor off direct", {updValid, updState, dirtyBusy}, 4'b1110);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule